// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a clean, flush or invalidate request on a cache block may go ahead. A request carries an operation code, a virtual address and the privilege level of the requester. The block sends the address to a translation port. If translation succeeds, it sends the physical address to a memory protection port. The protection check always asks for read permission, whatever the operation code, and gives the configured cache-block size as the access width.

Both ports are simple request/response pairs, and the responder may answer in any cycle, including the first. A fault from either stage is a load-style fault. The block reports it under the store/AMO fault codes and retires the request as failed. The failing result also carries the unaligned virtual address as the trap value. A separate configuration write sets the cache-block size, and values that are not legal are refused.

The state machine has four states:
- IDLE: ready for a request. The *accept* transition goes to XLATE.
- XLATE: the translation request is held. The *xlate-fault* transition goes to DONE, and the *xlate-ok* transition goes to PROT.
- PROT: the protection request is held. The *prot-resp* transition goes to DONE.
- DONE: the result is presented for one cycle. The *retire* transition goes back to IDLE.

Top module: `cbo_perm_check`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `cfg_blk_size` equals the default block size (64).
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low until the result has been given. Each accepted request yields exactly one result, and `res_valid` is high for exactly one cycle.
- R3: Translation is asked first, with the captured virtual address and privilege. The protection request is raised only after a translation response with fault code 0, and it carries the translated physical address. `xl_req_valid` and `pmp_req_valid` are never high together.
- R4: For every operation code (clean=0, flush=1, inval=2), `pmp_req_kind` is the read code 2'b00. `pmp_req_width` is the block size that was in force when the request was accepted.
- R5: If neither stage faults, the result has `res_ok`=1, `res_cause`=0 and `res_tval`=0.
- R6: A translation fault code of 1 (load access fault) or 3 (reserved, treated as access), or a protection response with `pmp_rsp_deny`=1, gives `res_ok`=0 with cause 7 (store/AMO access fault).
- R7: A translation fault code of 2 (load page fault) gives `res_ok`=0 with cause 15 (store/AMO page fault). A translation fault skips the protection stage.
- R8: On a failed result, `res_tval` is the original virtual address, not aligned to the block. `res_op` echoes the operation code of the accepted request.
- R9: A write of `cfg_size` with `cfg_we` high is kept only if the value is a nonzero power of two below 4096. Any other value leaves the previous size unchanged.
- R10: When a configuration write and a request acceptance fall in the same cycle, that request uses the old size. The new size applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Block-size write strobe |
| cfg_size | input | SIZE_W | Proposed block size in bytes |
| cfg_blk_size | output | SIZE_W | Block size currently in force |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | Operation: 0 clean, 1 flush, 2 inval |
| req_vaddr | input | XLEN | Virtual address of the target |
| req_priv | input | 2 | Privilege of the requester |
| xl_req_valid | output | 1 | Translation request |
| xl_req_vaddr | output | XLEN | Address to translate |
| xl_req_priv | output | 2 | Privilege for translation |
| xl_rsp_valid | input | 1 | Translation answer present |
| xl_rsp_paddr | input | PA_W | Translated physical address |
| xl_rsp_fault | input | 2 | 0 none, 1 access, 2 page, 3 reserved (access) |
| pmp_req_valid | output | 1 | Protection check request |
| pmp_req_paddr | output | PA_W | Physical address to check |
| pmp_req_width | output | SIZE_W | Access width in bytes |
| pmp_req_kind | output | 2 | Access kind, always read (2'b00) |
| pmp_req_priv | output | 2 | Privilege for the check |
| pmp_rsp_valid | input | 1 | Protection answer present |
| pmp_rsp_deny | input | 1 | Access refused |
| res_valid | output | 1 | Result strobe |
| res_ok | output | 1 | 1 retire success, 0 retire fail |
| res_op | output | 2 | Operation code of the request |
| res_cause | output | 5 | Fault cause (7 or 15), 0 on success |
| res_tval | output | XLEN | Faulting virtual address, 0 on success |

## Verification
A configuration write and a request acceptance can happen in the same cycle.
- **How it is provoked:** the bench raises `cfg_we` with a new legal size on the same clock edge that `req_valid` meets an idle block.
- **How it is judged:** the width shown on the protection port for that request must equal the size before the write. `cfg_blk_size` must read the new size afterwards.

A second overlap also happens: a zero-latency response arrives in the cycle in which the stage request first appears. The bench provokes it with latency-0 vectors and checks the result cause against the table.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE         = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_STAMO_ACCESS = 5'd7;
    localparam logic [CAUSE_W-1:0] CAUSE_STAMO_PAGE   = 5'd15;

    localparam logic [1:0] ACC_KIND_READ = 2'b00;

    typedef enum logic [1:0] {
        LF_NONE   = 2'd0,
        LF_ACCESS = 2'd1,
        LF_PAGE   = 2'd2,
        LF_RSVD   = 2'd3
    } load_fault_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_XLATE = 2'd1,
        S_PROT  = 2'd2,
        S_DONE  = 2'd3
    } chk_state_e;

endpackage

// File: rtl/cbo_blk_size_reg.sv
module cbo_blk_size_reg #(
    parameter int SIZE_W  = 13,
    parameter int DEF_BLK = 64,
    parameter int LIMIT   = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SIZE_W-1:0] wr_size,
    output logic [SIZE_W-1:0] size_q
);
    localparam logic [SIZE_W-1:0] LIMIT_V = SIZE_W'(LIMIT);
    localparam logic [SIZE_W-1:0] DEF_V   = SIZE_W'(DEF_BLK);

    logic legal;

    always_comb begin
        legal = (wr_size != '0) &&
                ((wr_size & (wr_size - SIZE_W'(1))) == '0) &&
                (wr_size < LIMIT_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= DEF_V;
        end else if (wr_en && legal) begin
            size_q <= wr_size;
        end
    end
endmodule

// File: rtl/cbo_fault_remap.sv
module cbo_fault_remap
    import cbo_perm_pkg::*;
(
    input  load_fault_e          load_fault,
    output logic                 fail,
    output logic [CAUSE_W-1:0]   cause
);
    always_comb begin
        unique case (load_fault)
            LF_NONE: begin
                fail  = 1'b0;
                cause = CAUSE_NONE;
            end
            LF_PAGE: begin
                fail  = 1'b1;
                cause = CAUSE_STAMO_PAGE;
            end
            LF_ACCESS, LF_RSVD: begin
                fail  = 1'b1;
                cause = CAUSE_STAMO_ACCESS;
            end
            default: begin
                fail  = 1'b1;
                cause = CAUSE_STAMO_ACCESS;
            end
        endcase
    end
endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
    import cbo_perm_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int PA_W    = 56,
    parameter int SIZE_W  = 13,
    parameter int DEF_BLK = 64,
    parameter int LIMIT   = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SIZE_W-1:0]   cfg_size,
    output logic [SIZE_W-1:0]   cfg_blk_size,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [XLEN-1:0]     req_vaddr,
    input  logic [1:0]          req_priv,
    output logic                xl_req_valid,
    output logic [XLEN-1:0]     xl_req_vaddr,
    output logic [1:0]          xl_req_priv,
    input  logic                xl_rsp_valid,
    input  logic [PA_W-1:0]     xl_rsp_paddr,
    input  logic [1:0]          xl_rsp_fault,
    output logic                pmp_req_valid,
    output logic [PA_W-1:0]     pmp_req_paddr,
    output logic [SIZE_W-1:0]   pmp_req_width,
    output logic [1:0]          pmp_req_kind,
    output logic [1:0]          pmp_req_priv,
    input  logic                pmp_rsp_valid,
    input  logic                pmp_rsp_deny,
    output logic                res_valid,
    output logic                res_ok,
    output logic [1:0]          res_op,
    output logic [CAUSE_W-1:0]  res_cause,
    output logic [XLEN-1:0]     res_tval
);
    chk_state_e          state_q, state_d;
    logic [1:0]          op_q;
    logic [XLEN-1:0]     vaddr_q;
    logic [1:0]          priv_q;
    logic [SIZE_W-1:0]   width_q;
    logic [PA_W-1:0]     paddr_q;
    load_fault_e         fault_q;
    logic                map_fail;
    logic [CAUSE_W-1:0]  map_cause;

    cbo_blk_size_reg #(
        .SIZE_W (SIZE_W),
        .DEF_BLK(DEF_BLK),
        .LIMIT  (LIMIT)
    ) u_size (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_size(cfg_size),
        .size_q (cfg_blk_size)
    );

    cbo_fault_remap u_remap (
        .load_fault(fault_q),
        .fail      (map_fail),
        .cause     (map_cause)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_XLATE;
            S_XLATE: if (xl_rsp_valid) begin
                         state_d = (xl_rsp_fault != 2'd0) ? S_DONE : S_PROT;
                     end
            S_PROT:  if (pmp_rsp_valid) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            vaddr_q <= '0;
            priv_q  <= '0;
            width_q <= '0;
            paddr_q <= '0;
            fault_q <= LF_NONE;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q    <= req_op;
                    vaddr_q <= req_vaddr;
                    priv_q  <= req_priv;
                    width_q <= cfg_blk_size;
                    fault_q <= LF_NONE;
                end
                S_XLATE: if (xl_rsp_valid) begin
                    fault_q <= load_fault_e'(xl_rsp_fault);
                    paddr_q <= xl_rsp_paddr;
                end
                S_PROT: if (pmp_rsp_valid) begin
                    fault_q <= pmp_rsp_deny ? LF_ACCESS : LF_NONE;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        xl_req_valid  = (state_q == S_XLATE);
        xl_req_vaddr  = vaddr_q;
        xl_req_priv   = priv_q;
        pmp_req_valid = (state_q == S_PROT);
        pmp_req_paddr = paddr_q;
        pmp_req_width = width_q;
        pmp_req_kind  = ACC_KIND_READ;
        pmp_req_priv  = priv_q;
        res_valid     = (state_q == S_DONE);
        res_ok        = !map_fail;
        res_op        = op_q;
        res_cause     = map_fail ? map_cause : CAUSE_NONE;
        res_tval      = map_fail ? vaddr_q : '0;
    end
endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva #(
    parameter int XLEN   = 64,
    parameter int SIZE_W = 13,
    parameter int LIMIT  = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              xl_req_valid,
    input logic [XLEN-1:0]   xl_req_vaddr,
    input logic              xl_rsp_valid,
    input logic [1:0]        xl_rsp_fault,
    input logic              pmp_req_valid,
    input logic [1:0]        pmp_req_kind,
    input logic              res_valid,
    input logic              res_ok,
    input logic [4:0]        res_cause,
    input logic [SIZE_W-1:0] cfg_blk_size
);
    assert_res_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_valid || pmp_req_valid || res_valid) |-> !req_ready);

    assert_stage_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req_valid && pmp_req_valid));

    assert_xlate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_valid && !xl_rsp_valid) |=> (xl_req_valid && $stable(xl_req_vaddr)));

    assert_xfault_skips_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_valid && xl_rsp_valid && xl_rsp_fault != 2'd0) |=> (res_valid && !pmp_req_valid));

    assert_read_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pmp_req_valid |-> (pmp_req_kind == 2'b00));

    assert_ok_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ok) |-> (res_cause == 5'd0));

    assert_fail_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ok) |-> (res_cause == 5'd7 || res_cause == 5'd15));

    assert_size_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cfg_blk_size) == 1) && (cfg_blk_size < SIZE_W'(LIMIT)));
endmodule

bind cbo_perm_check cbo_perm_check_sva #(
    .XLEN  (XLEN),
    .SIZE_W(SIZE_W),
    .LIMIT (LIMIT)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .xl_req_valid (xl_req_valid),
    .xl_req_vaddr (xl_req_vaddr),
    .xl_rsp_valid (xl_rsp_valid),
    .xl_rsp_fault (xl_rsp_fault),
    .pmp_req_valid(pmp_req_valid),
    .pmp_req_kind (pmp_req_kind),
    .res_valid    (res_valid),
    .res_ok       (res_ok),
    .res_cause    (res_cause),
    .cfg_blk_size (cfg_blk_size)
);

// File: tb/cbo_perm_check_bench.sv
module cbo_perm_check_bench;
    localparam int XLEN   = 64;
    localparam int PA_W   = 56;
    localparam int SIZE_W = 13;

    typedef struct packed {
        logic [1:0]      op;
        logic [XLEN-1:0] vaddr;
        logic [1:0]      priv;
        logic [1:0]      xf;
        logic [PA_W-1:0] paddr;
        logic            deny;
        logic [2:0]      xlat;
        logic [2:0]      plat;
        logic            exp_ok;
        logic [4:0]      exp_cause;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'h0000_0000_8000_1234, 2'd1, 2'd0, 56'h0_8000_1234, 1'b0, 3'd0, 3'd0, 1'b1, 5'd0},
        '{2'd1, 64'h0000_0000_4000_0ff8, 2'd0, 2'd1, 56'h0,           1'b0, 3'd1, 3'd0, 1'b0, 5'd7},
        '{2'd2, 64'hFFFF_FFC0_0000_1003, 2'd1, 2'd2, 56'h0,           1'b0, 3'd0, 3'd0, 1'b0, 5'd15},
        '{2'd0, 64'h0000_0012_3456_7891, 2'd0, 2'd0, 56'h0_00AB_CD80, 1'b1, 3'd2, 3'd1, 1'b0, 5'd7},
        '{2'd1, 64'h0000_0000_0000_0040, 2'd1, 2'd0, 56'h0_1000_0040, 1'b0, 3'd3, 3'd3, 1'b1, 5'd0},
        '{2'd2, 64'h0000_7FFF_0000_0101, 2'd0, 2'd3, 56'h0,           1'b0, 3'd2, 3'd0, 1'b0, 5'd7},
        '{2'd2, 64'h0000_0000_9000_0007, 2'd1, 2'd0, 56'h0_9000_0007, 1'b1, 3'd0, 3'd0, 1'b0, 5'd7},
        '{2'd0, 64'h0000_0000_0DEA_DBEF, 2'd0, 2'd2, 56'h0,           1'b0, 3'd4, 3'd0, 1'b0, 5'd15}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [SIZE_W-1:0] cfg_blk_size;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [XLEN-1:0]   req_vaddr = '0;
    logic [1:0]        req_priv = '0;
    logic              xl_req_valid;
    logic [XLEN-1:0]   xl_req_vaddr;
    logic [1:0]        xl_req_priv;
    logic              xl_rsp_valid;
    logic              pmp_req_valid;
    logic [PA_W-1:0]   pmp_req_paddr;
    logic [SIZE_W-1:0] pmp_req_width;
    logic [1:0]        pmp_req_kind;
    logic [1:0]        pmp_req_priv;
    logic              pmp_rsp_valid;
    logic              res_valid;
    logic              res_ok;
    logic [1:0]        res_op;
    logic [4:0]        res_cause;
    logic [XLEN-1:0]   res_tval;

    logic [1:0]      cur_xf = '0;
    logic [PA_W-1:0] cur_paddr = '0;
    logic            cur_deny = 1'b0;
    logic [2:0]      cur_xlat = '0;
    logic [2:0]      cur_plat = '0;
    logic [3:0]      xl_cnt, pmp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_cnt  <= '0;
            pmp_cnt <= '0;
        end else begin
            xl_cnt  <= xl_req_valid  ? xl_cnt + 4'd1  : 4'd0;
            pmp_cnt <= pmp_req_valid ? pmp_cnt + 4'd1 : 4'd0;
        end
    end

    assign xl_rsp_valid  = xl_req_valid  && (xl_cnt  >= {1'b0, cur_xlat});
    assign pmp_rsp_valid = pmp_req_valid && (pmp_cnt >= {1'b0, cur_plat});

    cbo_perm_check u_cbo_perm_check (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_size(cfg_size), .cfg_blk_size(cfg_blk_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_vaddr(req_vaddr), .req_priv(req_priv),
        .xl_req_valid(xl_req_valid), .xl_req_vaddr(xl_req_vaddr), .xl_req_priv(xl_req_priv),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_paddr(cur_paddr), .xl_rsp_fault(cur_xf),
        .pmp_req_valid(pmp_req_valid), .pmp_req_paddr(pmp_req_paddr),
        .pmp_req_width(pmp_req_width), .pmp_req_kind(pmp_req_kind), .pmp_req_priv(pmp_req_priv),
        .pmp_rsp_valid(pmp_rsp_valid), .pmp_rsp_deny(cur_deny),
        .res_valid(res_valid), .res_ok(res_ok), .res_op(res_op),
        .res_cause(res_cause), .res_tval(res_tval)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [SIZE_W-1:0] sz);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_size = sz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one request through the block; cfg_same writes a new size in the acceptance cycle
    task automatic run_vec(input vec_t v, input logic [SIZE_W-1:0] exp_w,
                           input logic cfg_same, input logic [SIZE_W-1:0] new_sz);
        logic got = 1'b0;
        logic pmp_seen = 1'b0;
        @(negedge clk);
        cur_xf = v.xf; cur_paddr = v.paddr; cur_deny = v.deny;
        cur_xlat = v.xlat; cur_plat = v.plat;
        req_valid = 1'b1; req_op = v.op; req_vaddr = v.vaddr; req_priv = v.priv;
        if (cfg_same) begin
            cfg_we = 1'b1;
            cfg_size = new_sz;
        end
        chk(req_ready, "R2 ready in idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b0;
        req_vaddr = ~v.vaddr;
        chk(!req_ready, "R2 busy after accept", 64'(req_ready), 64'd0);
        chk(xl_req_valid && xl_req_vaddr == v.vaddr && xl_req_priv == v.priv,
            "R3 translation request", xl_req_vaddr, v.vaddr);
        if (cfg_same)
            chk(cfg_blk_size == new_sz, "R10 new size visible", 64'(cfg_blk_size), 64'(new_sz));
        for (int n = 0; n < 40 && !got; n++) begin
            if (pmp_req_valid && !pmp_seen) begin
                pmp_seen = 1'b1;
                chk(pmp_req_paddr == v.paddr, "R3 protection paddr", 64'(pmp_req_paddr), 64'(v.paddr));
                chk(pmp_req_kind == 2'b00 && pmp_req_priv == v.priv, "R4 read kind",
                    64'(pmp_req_kind), 64'd0);
                chk(pmp_req_width == exp_w, cfg_same ? "R10 old width used" : "R4 width",
                    64'(pmp_req_width), 64'(exp_w));
            end
            if (res_valid) got = 1'b1;
            else @(negedge clk);
        end
        chk(got, "R2 result produced", 64'(got), 64'd1);
        chk(pmp_seen == (v.xf == 2'd0), "R7 protection only after clean translation",
            64'(pmp_seen), 64'(v.xf == 2'd0));
        chk(res_ok == v.exp_ok && res_cause == v.exp_cause,
            v.exp_ok ? "R5 success" : (v.exp_cause == 5'd15 ? "R7 page cause" : "R6 access cause"),
            {59'd0, res_cause}, {59'd0, v.exp_cause});
        chk(res_tval == (v.exp_ok ? 64'd0 : v.vaddr), "R8 trap value", res_tval,
            v.exp_ok ? 64'd0 : v.vaddr);
        chk(res_op == v.op, "R8 op echo", 64'(res_op), 64'(v.op));
        @(negedge clk);
        chk(!res_valid && req_ready, "R2 single result pulse", 64'(res_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(res_valid == 1'b0, "R1 no result at reset", 64'(res_valid), 64'd0);
        chk(cfg_blk_size == 13'd64, "R1 default size", 64'(cfg_blk_size), 64'd64);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 13'd64, 1'b0, '0);
        end

        // R9 configuration legality
        cfg_write(13'd128);
        chk(cfg_blk_size == 13'd128, "R9 accept 128", 64'(cfg_blk_size), 64'd128);
        cfg_write(13'd96);
        chk(cfg_blk_size == 13'd128, "R9 reject 96", 64'(cfg_blk_size), 64'd128);
        cfg_write(13'd4096);
        chk(cfg_blk_size == 13'd128, "R9 reject 4096", 64'(cfg_blk_size), 64'd128);
        cfg_write(13'd0);
        chk(cfg_blk_size == 13'd128, "R9 reject 0", 64'(cfg_blk_size), 64'd128);
        cfg_write(13'd2048);
        chk(cfg_blk_size == 13'd2048, "R9 accept 2048", 64'(cfg_blk_size), 64'd2048);
        run_vec(VECS[0], 13'd2048, 1'b0, '0);

        // R10 config write in the acceptance cycle
        run_vec(VECS[4], 13'd2048, 1'b1, 13'd256);
        run_vec(VECS[3], 13'd256, 1'b0, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule